// File: doc/BRIEF.md
# Dual Modulo Address Generator

This block supplies two data-memory addresses in every clock cycle, one for an X-side memory and one for a Y-side memory. Each side owns a small bank of pointer registers. Every pointer has its own stepping configuration: count up, count down, add a signed step, wrap inside a power-of-two aligned block, or wrap inside a ring between a start address and start plus N-1. On each cycle a side chooses one pointer. The chosen pointer's current value goes to the address output. If an update is requested, the pointer then moves according to its configuration, so each memory access and its post-modify take place together.

The two sides share nothing but the clock and reset. A sequencer drives each side with a pointer select and an update strobe. Software-visible state reaches the block through two paths: a configuration write per pointer, and a direct load of a pointer's value. A direct load has priority over a step on the same pointer. The address is registered, so it appears on the cycle after the select.

Top module: `dual_addr_gen`

## Requirements
- R1: After a synchronous reset, every pointer and both address outputs are 0, and every pointer's configuration is increment mode (mode code 0) with zero step, zero length and zero ring start.
- R2: The address output in the cycle after a select with index i (0..2) equals pointer i's value before any update made at that edge. A select index of 3 gives an address of 0 and changes no pointer.
- R3: Mode code 0 adds 1 to the pointer on an update and wraps from all ones to 0.
- R4: Mode code 1 subtracts 1 from the pointer on an update.
- R5: Mode code 2 adds the step field to the pointer. The step field is configuration bits [10:3], read as an 8-bit two's-complement value and sign-extended.
- R6: Mode code 3 treats the pointer as lying in an aligned block of 2^L words, where L is configuration bits [18:11]. The low L bits become (low bits + step) mod 2^L and the upper bits are kept.
- R7: Mode code 4 wraps the pointer within the ring from start S to S+N-1, where N is configuration bits [18:11] and S is the ring-start input. A positive step past the top subtracts N, and a negative step below S adds N.
- R8: Mode codes 5 to 7 leave the pointer unchanged on an update.
- R9: A direct load writes the given value into the given pointer. When it targets the pointer being updated in the same cycle, the loaded value wins.
- R10: The X and Y sides work at the same time. No input of one side changes the other side's pointers or address.
- R11: An update changes only the selected pointer. The other pointers of that side keep their values.
- R12: Without an update or a load, reading a pointer repeatedly returns the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_sel | input | 2 | X pointer select (3 = none) |
| x_upd | input | 1 | Post-modify the selected X pointer |
| x_ld | input | 1 | Direct load strobe, X side |
| x_ld_idx | input | 2 | X pointer to load |
| x_ld_val | input | 16 | Value to load |
| x_cfg_we | input | 1 | Configuration write strobe, X side |
| x_cfg_idx | input | 2 | X pointer whose configuration is written |
| x_cfg_ctrl | input | 19 | {length[18:11], step[10:3], mode[2:0]} |
| x_cfg_base | input | 16 | Ring start for mode 4 |
| x_addr | output | 16 | Registered X address |
| y_sel | input | 2 | Y pointer select (3 = none) |
| y_upd | input | 1 | Post-modify the selected Y pointer |
| y_ld | input | 1 | Direct load strobe, Y side |
| y_ld_idx | input | 2 | Y pointer to load |
| y_ld_val | input | 16 | Value to load |
| y_cfg_we | input | 1 | Configuration write strobe, Y side |
| y_cfg_idx | input | 2 | Y pointer whose configuration is written |
| y_cfg_ctrl | input | 19 | {length[18:11], step[10:3], mode[2:0]} |
| y_cfg_base | input | 16 | Ring start for mode 4 |
| y_addr | output | 16 | Registered Y address |

## Verification
Three properties are checked on every cycle, for each side, at the ports only: a load is seen on the next read of that pointer, an idle select gives zero, and a pointer that is read twice without an update or load holds its value. The arithmetic of each stepping mode cannot be seen from the ports without knowing the configuration, so it is shown only by the bench scenarios. These cover increment wrap, signed steps, aligned-block wrap in both directions, ring wrap at both ends, hold codes, load-over-update priority, and simultaneous traffic on both sides.

// File: rtl/agu_pkg.sv
package agu_pkg;
  parameter int MODE_W = 3;
  parameter int OFS_W  = 8;
  parameter int LEN_W  = 8;
  localparam int CTRL_W = MODE_W + OFS_W + LEN_W;

  typedef enum logic [MODE_W-1:0] {
    M_INC  = 3'd0,
    M_DEC  = 3'd1,
    M_OFS  = 3'd2,
    M_BLK  = 3'd3,
    M_RING = 3'd4
  } step_mode_e;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [OFS_W-1:0]  ofs;
    logic [MODE_W-1:0] mode;
  } ptr_ctrl_t;
endpackage

// File: rtl/agu_next.sv
module agu_next
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur_i,
  input  ptr_ctrl_t     ctrl_i,
  input  logic [AW-1:0] ring_base_i,
  output logic [AW-1:0] nxt_o
);
  localparam int WW = AW + 2;

  logic signed [WW-1:0] step_w, sum_w, lo_w, hi_w, n_w, ring_w;
  logic [AW-1:0] blk_mask;

  always_comb begin
    step_w = {{(WW-OFS_W){ctrl_i.ofs[OFS_W-1]}}, ctrl_i.ofs};
    n_w    = {{(WW-LEN_W){1'b0}}, ctrl_i.len};
    sum_w  = {2'b00, cur_i} + step_w;
    lo_w   = {2'b00, ring_base_i};
    hi_w   = lo_w + n_w - WW'(1);

    if (ctrl_i.len >= LEN_W'(AW)) blk_mask = '1;
    else                          blk_mask = (AW'(1) << ctrl_i.len) - AW'(1);

    if (!ctrl_i.ofs[OFS_W-1] && (sum_w > hi_w))     ring_w = sum_w - n_w;
    else if (ctrl_i.ofs[OFS_W-1] && (sum_w < lo_w)) ring_w = sum_w + n_w;
    else                                            ring_w = sum_w;

    case (ctrl_i.mode)
      M_INC:   nxt_o = cur_i + AW'(1);
      M_DEC:   nxt_o = cur_i - AW'(1);
      M_OFS:   nxt_o = sum_w[AW-1:0];
      M_BLK:   nxt_o = (cur_i & ~blk_mask) | (sum_w[AW-1:0] & blk_mask);
      M_RING:  nxt_o = ring_w[AW-1:0];
      default: nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/agu_unit.sv
module agu_unit
  import agu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NPTR = 3,
  localparam int IW  = $clog2(NPTR + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] sel_i,
  input  logic          upd_i,
  input  logic          ld_i,
  input  logic [IW-1:0] ld_idx_i,
  input  logic [AW-1:0] ld_val_i,
  input  logic          cfg_we_i,
  input  logic [IW-1:0] cfg_idx_i,
  input  ptr_ctrl_t     cfg_ctrl_i,
  input  logic [AW-1:0] cfg_base_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] ptr_q  [NPTR];
  logic [AW-1:0] base_q [NPTR];
  ptr_ctrl_t     ctrl_q [NPTR];
  logic [AW-1:0] nxt_w  [NPTR];
  logic [AW-1:0] rd_w;

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    agu_next #(.AW(AW)) u_next (
      .cur_i       (ptr_q[i]),
      .ctrl_i      (ctrl_q[i]),
      .ring_base_i (base_q[i]),
      .nxt_o       (nxt_w[i])
    );

    always_ff @(posedge clk) begin
      if (rst)                                ptr_q[i] <= '0;
      else if (ld_i && ld_idx_i == IW'(i))    ptr_q[i] <= ld_val_i;
      else if (upd_i && sel_i == IW'(i))      ptr_q[i] <= nxt_w[i];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[i] <= '0;
        base_q[i] <= '0;
      end else if (cfg_we_i && cfg_idx_i == IW'(i)) begin
        ctrl_q[i] <= cfg_ctrl_i;
        base_q[i] <= cfg_base_i;
      end
    end
  end

  always_comb begin
    rd_w = '0;
    for (int i = 0; i < NPTR; i++)
      if (sel_i == IW'(i)) rd_w = ptr_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) addr_o <= '0;
    else     addr_o <= rd_w;
  end
endmodule

// File: rtl/dual_addr_gen.sv
module dual_addr_gen
  import agu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NPTR = 3,
  localparam int IW  = $clog2(NPTR + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IW-1:0]     x_sel,
  input  logic              x_upd,
  input  logic              x_ld,
  input  logic [IW-1:0]     x_ld_idx,
  input  logic [AW-1:0]     x_ld_val,
  input  logic              x_cfg_we,
  input  logic [IW-1:0]     x_cfg_idx,
  input  logic [CTRL_W-1:0] x_cfg_ctrl,
  input  logic [AW-1:0]     x_cfg_base,
  output logic [AW-1:0]     x_addr,
  input  logic [IW-1:0]     y_sel,
  input  logic              y_upd,
  input  logic              y_ld,
  input  logic [IW-1:0]     y_ld_idx,
  input  logic [AW-1:0]     y_ld_val,
  input  logic              y_cfg_we,
  input  logic [IW-1:0]     y_cfg_idx,
  input  logic [CTRL_W-1:0] y_cfg_ctrl,
  input  logic [AW-1:0]     y_cfg_base,
  output logic [AW-1:0]     y_addr
);
  localparam int NSIDE = 2;

  logic [NSIDE-1:0][IW-1:0]     sel_a, ldi_a, cfi_a;
  logic [NSIDE-1:0]             upd_a, ld_a, cwe_a;
  logic [NSIDE-1:0][AW-1:0]     ldv_a, cb_a, addr_a;
  logic [NSIDE-1:0][CTRL_W-1:0] cw_a;

  assign sel_a = {y_sel, x_sel};
  assign upd_a = {y_upd, x_upd};
  assign ld_a  = {y_ld, x_ld};
  assign ldi_a = {y_ld_idx, x_ld_idx};
  assign ldv_a = {y_ld_val, x_ld_val};
  assign cwe_a = {y_cfg_we, x_cfg_we};
  assign cfi_a = {y_cfg_idx, x_cfg_idx};
  assign cw_a  = {y_cfg_ctrl, x_cfg_ctrl};
  assign cb_a  = {y_cfg_base, x_cfg_base};

  for (genvar u = 0; u < NSIDE; u++) begin : g_side
    agu_unit #(.AW(AW), .NPTR(NPTR)) u_agu (
      .clk        (clk),
      .rst        (rst),
      .sel_i      (sel_a[u]),
      .upd_i      (upd_a[u]),
      .ld_i       (ld_a[u]),
      .ld_idx_i   (ldi_a[u]),
      .ld_val_i   (ldv_a[u]),
      .cfg_we_i   (cwe_a[u]),
      .cfg_idx_i  (cfi_a[u]),
      .cfg_ctrl_i (ptr_ctrl_t'(cw_a[u])),
      .cfg_base_i (cb_a[u]),
      .addr_o     (addr_a[u])
    );
  end

  assign x_addr = addr_a[0];
  assign y_addr = addr_a[1];
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int AW   = 16,
  parameter int NPTR = 3,
  parameter int IW   = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [IW-1:0] x_sel,
  input logic          x_upd,
  input logic          x_ld,
  input logic [IW-1:0] x_ld_idx,
  input logic [AW-1:0] x_ld_val,
  input logic [AW-1:0] x_addr,
  input logic [IW-1:0] y_sel,
  input logic          y_upd,
  input logic          y_ld,
  input logic [IW-1:0] y_ld_idx,
  input logic [AW-1:0] y_ld_val,
  input logic [AW-1:0] y_addr
);
  // R2: an out-of-range select reads as zero
  a_r2_x_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (x_sel >= IW'(NPTR)) |=> (x_addr == '0));
  a_r2_y_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (y_sel >= IW'(NPTR)) |=> (y_addr == '0));

  // R9: a loaded value is what the next read of that pointer returns
  a_r9_x_load_seen: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(x_ld) && x_sel == $past(x_ld_idx) && x_sel < IW'(NPTR))
      |=> (x_addr == $past(x_ld_val, 2)));
  a_r9_y_load_seen: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(y_ld) && y_sel == $past(y_ld_idx) && y_sel < IW'(NPTR))
      |=> (y_addr == $past(y_ld_val, 2)));

  // R12: no update and no load keeps the pointer's value
  a_r12_x_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && x_sel == $past(x_sel) && x_sel < IW'(NPTR) && !$past(x_upd) && !$past(x_ld))
      |=> (x_addr == $past(x_addr)));
  a_r12_y_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && y_sel == $past(y_sel) && y_sel < IW'(NPTR) && !$past(y_upd) && !$past(y_ld))
      |=> (y_addr == $past(y_addr)));
endmodule

bind dual_addr_gen agu_chk #(.AW(AW), .NPTR(NPTR), .IW(IW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .x_sel    (x_sel),
  .x_upd    (x_upd),
  .x_ld     (x_ld),
  .x_ld_idx (x_ld_idx),
  .x_ld_val (x_ld_val),
  .x_addr   (x_addr),
  .y_sel    (y_sel),
  .y_upd    (y_upd),
  .y_ld     (y_ld),
  .y_ld_idx (y_ld_idx),
  .y_ld_val (y_ld_val),
  .y_addr   (y_addr)
);

// File: tb/sim_dual_addr_gen.sv
module sim_dual_addr_gen;
  import agu_pkg::*;
  localparam int AW = 16;
  localparam int NPTR = 3;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [IW-1:0] x_sel, y_sel, x_ld_idx, y_ld_idx, x_cfg_idx, y_cfg_idx;
  logic x_upd, y_upd, x_ld, y_ld, x_cfg_we, y_cfg_we;
  logic [AW-1:0] x_ld_val, y_ld_val, x_cfg_base, y_cfg_base, x_addr, y_addr;
  logic [CTRL_W-1:0] x_cfg_ctrl, y_cfg_ctrl;

  dual_addr_gen #(.AW(AW), .NPTR(NPTR)) u0 (.*);

  logic [IW-1:0]     b_sel [2], b_ldi [2], b_ci [2];
  logic              b_upd [2], b_ld [2], b_cwe [2];
  logic [AW-1:0]     b_ldv [2], b_cb [2];
  logic [CTRL_W-1:0] b_cw [2];
  logic [AW-1:0]     m_ptr [2][NPTR];
  logic [AW-1:0]     m_base [2][NPTR];
  logic [CTRL_W-1:0] m_ctl [2][NPTR];

  typedef struct {
    string         req;
    int            unit;
    logic [AW-1:0] exp;
  } item_t;
  item_t sb [$];

  int checks = 0;
  int fails = 0;

  function automatic logic [AW-1:0] model_next(logic [AW-1:0] p, logic [CTRL_W-1:0] c,
                                               logic [AW-1:0] b);
    int mode, off, len, pi, r, sz, lowv;
    mode = int'(c[2:0]);
    off  = int'($signed(c[10:3]));
    len  = int'(c[18:11]);
    pi   = int'(p);
    case (mode)
      0: r = pi + 1;
      1: r = pi - 1;
      2: r = pi + off;
      3: begin
        sz   = (len >= AW) ? (1 << AW) : (1 << len);
        lowv = (((pi % sz) + off) % sz + sz) % sz;
        r    = pi - (pi % sz) + lowv;
      end
      4: begin
        r = pi + off;
        if (off >= 0 && r > int'(b) + len - 1) r = r - len;
        else if (off < 0 && r < int'(b)) r = r + len;
      end
      default: r = pi;
    endcase
    return r[AW-1:0];
  endfunction

  task automatic step(string req);
    item_t it [2];
    x_sel = b_sel[0]; x_upd = b_upd[0]; x_ld = b_ld[0]; x_ld_idx = b_ldi[0];
    x_ld_val = b_ldv[0]; x_cfg_we = b_cwe[0]; x_cfg_idx = b_ci[0];
    x_cfg_ctrl = b_cw[0]; x_cfg_base = b_cb[0];
    y_sel = b_sel[1]; y_upd = b_upd[1]; y_ld = b_ld[1]; y_ld_idx = b_ldi[1];
    y_ld_val = b_ldv[1]; y_cfg_we = b_cwe[1]; y_cfg_idx = b_ci[1];
    y_cfg_ctrl = b_cw[1]; y_cfg_base = b_cb[1];
    for (int u = 0; u < 2; u++) begin
      it[u].req  = req;
      it[u].unit = u;
      it[u].exp  = (int'(b_sel[u]) < NPTR) ? m_ptr[u][b_sel[u]] : '0;
      if (b_upd[u] && int'(b_sel[u]) < NPTR)
        m_ptr[u][b_sel[u]] = model_next(m_ptr[u][b_sel[u]], m_ctl[u][b_sel[u]],
                                        m_base[u][b_sel[u]]);
      if (b_ld[u]) m_ptr[u][b_ldi[u]] = b_ldv[u];
      if (b_cwe[u]) begin
        m_ctl[u][b_ci[u]]  = b_cw[u];
        m_base[u][b_ci[u]] = b_cb[u];
      end
    end
    @(posedge clk);
    sb.push_back(it[0]);
    sb.push_back(it[1]);
    @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      b_upd[u] = 1'b0; b_ld[u] = 1'b0; b_cwe[u] = 1'b0;
    end
  endtask

  task automatic do_rd(int u, int i, bit up, string req);
    b_sel[u] = IW'(i);
    b_upd[u] = up;
    step(req);
  endtask

  task automatic do_ld(int u, int i, int v, string req);
    b_ld[u] = 1'b1; b_ldi[u] = IW'(i); b_ldv[u] = AW'(v);
    step(req);
  endtask

  task automatic do_cfg(int u, int i, int mode, int off, int len, int base, string req);
    b_cwe[u] = 1'b1; b_ci[u] = IW'(i);
    b_cw[u]  = {8'(len), 8'(off), 3'(mode)};
    b_cb[u]  = AW'(base);
    step(req);
  endtask

  task automatic check_now(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // monitor: pops what the driver predicted for the previous edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check_now($sformatf("%s side %0d", it.req, it.unit),
                (it.unit == 0) ? x_addr : y_addr, it.exp);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int u = 0; u < 2; u++) begin
      b_sel[u] = '0; b_upd[u] = 1'b0; b_ld[u] = 1'b0; b_ldi[u] = '0; b_ldv[u] = '0;
      b_cwe[u] = 1'b0; b_ci[u] = '0; b_cw[u] = '0; b_cb[u] = '0;
      for (int i = 0; i < NPTR; i++) begin
        m_ptr[u][i] = '0; m_ctl[u][i] = '0; m_base[u][i] = '0;
      end
    end
    x_sel = '0; x_upd = 0; x_ld = 0; x_ld_idx = '0; x_ld_val = '0;
    x_cfg_we = 0; x_cfg_idx = '0; x_cfg_ctrl = '0; x_cfg_base = '0;
    y_sel = '0; y_upd = 0; y_ld = 0; y_ld_idx = '0; y_ld_val = '0;
    y_cfg_we = 0; y_cfg_idx = '0; y_cfg_ctrl = '0; y_cfg_base = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_now("R1 reset x_addr", x_addr, '0);
    check_now("R1 reset y_addr", y_addr, '0);
    for (int i = 0; i < NPTR; i++) begin
      do_rd(0, i, 0, "R1 x pointer after reset");
      do_rd(1, i, 0, "R1 y pointer after reset");
    end

    // R3 increment (default mode) with wrap
    repeat (3) do_rd(0, 0, 1, "R3 increment");
    do_ld(0, 0, 16'hFFFF, "R9 load");
    do_rd(0, 0, 1, "R3 read all ones");
    do_rd(0, 0, 0, "R3 wrap to zero");

    // R9 load wins over update on same pointer
    b_sel[0] = '0; b_upd[0] = 1'b1;
    do_ld(0, 0, 16'h1234, "R9 load with update");
    do_rd(0, 0, 0, "R9 loaded value kept");

    // R4 decrement
    do_cfg(1, 0, 1, 0, 0, 0, "R4 cfg");
    do_ld(1, 0, 5, "R4 load");
    repeat (3) do_rd(1, 0, 1, "R4 decrement");
    do_rd(1, 0, 0, "R4 final");

    // R5 signed offset
    do_cfg(0, 1, 2, 7, 0, 0, "R5 cfg +7");
    do_ld(0, 1, 100, "R5 load");
    repeat (2) do_rd(0, 1, 1, "R5 step +7");
    do_cfg(0, 1, 2, -3, 0, 0, "R5 cfg -3");
    repeat (2) do_rd(0, 1, 1, "R5 step -3");
    do_rd(0, 1, 0, "R5 final");

    // R11 other pointers untouched
    do_rd(0, 0, 0, "R11 x p0 unchanged");
    do_rd(0, 2, 0, "R11 x p2 unchanged");

    // R6 aligned block, length 8
    do_cfg(0, 2, 3, 3, 3, 0, "R6 cfg +3");
    do_ld(0, 2, 16'h0045, "R6 load");
    repeat (5) do_rd(0, 2, 1, "R6 block step +3");
    do_cfg(0, 2, 3, -3, 3, 0, "R6 cfg -3");
    repeat (2) do_rd(0, 2, 1, "R6 block step -3");
    do_rd(0, 2, 0, "R6 final");

    // R7 ring 0x20..0x24
    do_cfg(1, 1, 4, 2, 5, 16'h0020, "R7 cfg +2");
    do_ld(1, 1, 16'h0023, "R7 load");
    repeat (5) do_rd(1, 1, 1, "R7 ring step +2");
    do_cfg(1, 1, 4, -2, 5, 16'h0020, "R7 cfg -2");
    repeat (3) do_rd(1, 1, 1, "R7 ring step -2");
    do_rd(1, 1, 0, "R7 final");

    // R8 hold codes
    do_cfg(1, 2, 5, 4, 4, 0, "R8 cfg code 5");
    do_ld(1, 2, 9, "R8 load");
    repeat (2) do_rd(1, 2, 1, "R8 hold code 5");
    do_cfg(1, 2, 7, 1, 1, 0, "R8 cfg code 7");
    do_rd(1, 2, 1, "R8 hold code 7");
    do_rd(1, 2, 0, "R8 final");

    // R10 both sides together, Y load does not disturb X
    b_sel[0] = 2'd1; b_upd[0] = 1'b1;
    b_sel[1] = 2'd0; b_upd[1] = 1'b1;
    b_ld[1] = 1'b1; b_ldi[1] = 2'd1; b_ldv[1] = 16'hBEEF;
    step("R10 simultaneous");
    do_rd(0, 1, 0, "R10 x after y traffic");
    do_rd(1, 1, 0, "R10 y loaded");

    // R2 idle select and pre-update address
    do_rd(0, 3, 1, "R2 idle select x");
    do_rd(1, 3, 1, "R2 idle select y");
    do_rd(0, 0, 1, "R2 pre-update value");
    do_rd(0, 0, 0, "R2 post-update value");

    // R12 repeated reads stable
    do_rd(0, 1, 0, "R12 stable read");
    do_rd(0, 1, 0, "R12 stable read");

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule